// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Target

This block is the responding side of a synchronous parallel bus whose 32 lines carry an address in the first cycle of a transaction and data in the cycles that follow. Every bus signal is sampled on the rising clock edge. An initiator opens a transaction by pulling its active-low frame line low. In that first cycle the target captures the address and the 4-bit command. If the address lies inside the target's window and the command is one it serves, the target claims the cycle by pulling its active-low device-select line low.

After claiming, the target runs data phases. A phase finishes only in a cycle where the initiator's ready line and the target's ready line are both low. Bursts send the address only once. The target keeps its own word offset and steps it on every finished phase. The offset wraps inside the window.

On the local side sits a zero-wait register or memory port. Writes appear there as a one-cycle strobe with offset, data and byte enables. Reads take their data combinationally from the port's read bus while the target drives the shared lines.

Top module: `mbus_target`

## Requirements
- R1: While reset is held and after its release with no transaction, devsel_n and trdy_n are high and ad_oe is low.
- R2: A transaction starts when frame_n is sampled low after a cycle with frame_n high. It is claimed when its address lies in [BASE_ADDR, BASE_ADDR + 2^WIN_BITS) and cbe_n is 4'b0110 (read) or 4'b0111 (write). devsel_n then goes low in the cycle after the address phase, and it is never low during the address phase itself.
- R3: An address outside the window, or any other command, leaves devsel_n high for the whole transaction and raises neither local strobe.
- R4: trdy_n goes low exactly one cycle after devsel_n goes low and stays low until the transaction ends.
- R5: In a write, loc_we is high only in a cycle where irdy_n and trdy_n are both low. In that cycle loc_wdata equals ad_in and loc_be equals ~cbe_n, with bit i enabling byte i.
- R6: In a read, ad_oe is low in the turnaround cycle after the address phase. It is high only while trdy_n is low. In a finishing phase ad_out carries the local word at the current offset.
- R7: The word offset starts at address bits [WIN_BITS-1:2]. It advances by one on each finished phase only, and wraps modulo 2^(WIN_BITS-2).
- R8: When a phase finishes with frame_n high, devsel_n and trdy_n are high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | Initiator transaction frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| cbe_n | input | 4 | Command in address phase, inverted byte enables in data phases |
| ad_in | input | 32 | Shared lines as seen by the target |
| ad_out | output | 32 | Read data driven onto the shared lines |
| ad_oe | output | 1 | Enable for ad_out onto the shared lines |
| devsel_n | output | 1 | Target claims the transaction, active low |
| trdy_n | output | 1 | Target ready, active low |
| loc_addr | output | WIN_BITS-2 | Word offset into the local port |
| loc_wdata | output | 32 | Local write data |
| loc_be | output | 4 | Local byte enables, active high |
| loc_we | output | 1 | Local write strobe |
| loc_re | output | 1 | Local read strobe |
| loc_rdata | input | 32 | Local read data, zero wait |

## Verification
The bench stresses three things: initiator wait states, and in particular a wait in the claim cycle; a burst whose offset wraps past the top of the window; and single-phase transactions where frame_n rises in the first phase. A target that completes a phase on irdy_n alone would strobe the local port twice or skip words, and that shows up as write data landing at the wrong offset. A target that drives the lines in the turnaround cycle, or that misses the final phase and holds devsel_n, fails the cycle-exact checks. Decoding on stale address bits or on the wrong command codes shows up as claims on misses or on unsupported commands.

// File: rtl/mbt_pkg.sv
package mbt_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_CLAIM, PH_XFER} phase_t;

  localparam logic [3:0] CMD_READ  = 4'b0110;
  localparam logic [3:0] CMD_WRITE = 4'b0111;

  // address lies in the aligned window of 2^wb bytes at base
  function automatic logic in_window(input logic [31:0] a, input logic [31:0] base,
                                     input int unsigned wb);
    return ((a ^ base) >> wb) == 32'd0;
  endfunction

  function automatic logic cmd_served(input logic [3:0] c);
    return (c == CMD_READ) || (c == CMD_WRITE);
  endfunction
endpackage

// File: rtl/mbt_decode.sv
module mbt_decode #(
  parameter logic [31:0] BASE_ADDR = 32'h4000_0000,
  parameter int unsigned WIN_BITS  = 6,
  localparam int unsigned OFF_W    = WIN_BITS - 2
) (
  input  logic [31:0]      ad,
  input  logic [3:0]       cmd,
  output logic             hit,
  output logic             is_write,
  output logic [OFF_W-1:0] first_off
);
  import mbt_pkg::*;
  always_comb begin
    hit       = in_window(ad, BASE_ADDR, WIN_BITS) && cmd_served(cmd);
    is_write  = (cmd == CMD_WRITE);
    first_off = ad[WIN_BITS-1:2];
  end
endmodule

// File: rtl/mbt_offset_ctr.sv
module mbt_offset_ctr #(
  parameter int unsigned OFF_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OFF_W-1:0] load_val,
  input  logic             adv,
  output logic [OFF_W-1:0] off
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    off <= '0;
    else if (load) off <= load_val;
    else if (adv)  off <= off + 1'b1;
  end

  // R7
  wrap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> off == OFF_W'($past(off) + 1'b1));
endmodule

// File: rtl/mbt_phase_fsm.sv
module mbt_phase_fsm (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            claim,
  input  logic            xfer_done,
  input  logic            frame_n,
  output mbt_pkg::phase_t phase
);
  import mbt_pkg::*;
  phase_t nxt;

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_IDLE:  if (start && claim) nxt = PH_CLAIM;
      PH_CLAIM: nxt = PH_XFER;
      PH_XFER:  if (xfer_done && frame_n) nxt = PH_IDLE;
      default:  nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= nxt;
  end
endmodule

// File: rtl/mbus_target.sv
module mbus_target #(
  parameter logic [31:0] BASE_ADDR = 32'h4000_0000,
  parameter int unsigned WIN_BITS  = 6,
  localparam int unsigned OFF_W    = WIN_BITS - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic [3:0]       cbe_n,
  input  logic [31:0]      ad_in,
  output logic [31:0]      ad_out,
  output logic             ad_oe,
  output logic             devsel_n,
  output logic             trdy_n,
  output logic [OFF_W-1:0] loc_addr,
  output logic [31:0]      loc_wdata,
  output logic [3:0]       loc_be,
  output logic             loc_we,
  output logic             loc_re,
  input  logic [31:0]      loc_rdata
);
  import mbt_pkg::*;

  phase_t     phase;
  logic       frame_q, wr_q;
  logic       hit, dec_wr;
  logic [OFF_W-1:0] dec_off;

  // named events for the assertions
  logic start, claim, xfer_done;

  mbt_decode #(.BASE_ADDR(BASE_ADDR), .WIN_BITS(WIN_BITS)) u_dec (
    .ad(ad_in), .cmd(cbe_n), .hit(hit), .is_write(dec_wr), .first_off(dec_off)
  );

  assign start     = (phase == PH_IDLE) && !frame_n && frame_q;
  assign claim     = hit;
  assign xfer_done = (phase == PH_XFER) && !irdy_n;

  mbt_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .claim(claim),
    .xfer_done(xfer_done), .frame_n(frame_n), .phase(phase)
  );

  mbt_offset_ctr #(.OFF_W(OFF_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(start), .load_val(dec_off),
    .adv(xfer_done), .off(loc_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= 1'b1;
      wr_q    <= 1'b0;
    end else begin
      frame_q <= frame_n;
      if (start && claim) wr_q <= dec_wr;
    end
  end

  assign devsel_n  = (phase == PH_IDLE);
  assign trdy_n    = (phase != PH_XFER);
  assign ad_oe     = (phase == PH_XFER) && !wr_q;
  assign ad_out    = loc_rdata;
  assign loc_wdata = ad_in;
  assign loc_be    = ~cbe_n;
  assign loc_we    = xfer_done && wr_q;
  assign loc_re    = xfer_done && !wr_q;

  // R2
  claim_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && claim) |=> !devsel_n);
  // R3
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !claim) |=> devsel_n);
  // R4
  ready_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n) |=> !trdy_n);
  // R5
  strobe_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loc_we |-> (!irdy_n && !trdy_n));
  // R6
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n) |-> (!ad_oe && trdy_n));
  // R6
  drive_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> !trdy_n);
  // R7
  burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !frame_n) |=> loc_addr == OFF_W'($past(loc_addr) + 1'b1));
  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && frame_n) |=> (devsel_n && trdy_n));
endmodule

// File: tb/sim_mbus_target.sv
module sim_mbus_target;
  localparam logic [31:0] BASE = 32'h4000_0000;
  localparam int NW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, frame_n, irdy_n;
  logic [3:0]  cbe_n;
  logic [31:0] ad_in, ad_out, loc_wdata, loc_rdata;
  logic ad_oe, devsel_n, trdy_n, loc_we, loc_re;
  logic [3:0] loc_addr, loc_be;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  logic [31:0] lmem [NW];
  logic [31:0] emem [NW];

  mbus_target u0 (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .cbe_n(cbe_n),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .devsel_n(devsel_n), .trdy_n(trdy_n),
    .loc_addr(loc_addr), .loc_wdata(loc_wdata), .loc_be(loc_be), .loc_we(loc_we),
    .loc_re(loc_re), .loc_rdata(loc_rdata)
  );

  // zero-wait local memory behind the target
  assign loc_rdata = lmem[loc_addr];
  always @(posedge clk)
    if (loc_we)
      for (int b = 0; b < 4; b++)
        if (loc_be[b]) lmem[loc_addr][8*b +: 8] <= loc_wdata[8*b +: 8];

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic txn(input logic [31:0] addr, input logic [3:0] cmd, input int n,
                     input bit expect_claim);
    int off, done, cyc;
    bit fr_up, wt, wr;
    logic [3:0] be;
    logic [31:0] wd;
    off = int'(addr[5:2]); done = 0; cyc = 0; fr_up = 0; wr = (cmd == 4'b0111);
    @(negedge clk);
    frame_n = 0; irdy_n = 1; ad_in = addr; cbe_n = cmd; #1;
    chk(devsel_n === 1'b1, "R2 no claim in address phase", {31'd0, devsel_n}, 1);
    if (!expect_claim) begin
      repeat (4) begin
        @(negedge clk);
        irdy_n = 0; ad_in = $urandom; cbe_n = 4'h0; #1;
        chk(devsel_n === 1'b1 && !loc_we && !loc_re, "R3 ignored transaction",
            {29'd0, devsel_n, loc_we, loc_re}, 32'h4);
      end
      @(negedge clk);
      frame_n = 1; irdy_n = 1; #1;
      chk(devsel_n === 1'b1, "R3 idle after miss", {31'd0, devsel_n}, 1);
      return;
    end
    while (done < n) begin
      @(negedge clk);
      wt = !fr_up && ($urandom % 4 == 0);
      if (!wt && done == n - 1) fr_up = 1;
      irdy_n = wt; frame_n = fr_up;
      be = 4'($urandom); wd = $urandom;
      cbe_n = ~be; ad_in = wd; #1;
      if (cyc == 0) begin
        chk(!devsel_n && trdy_n, "R4 claim cycle has devsel low trdy high",
            {30'd0, devsel_n, trdy_n}, 32'h1);
        chk(!ad_oe, "R6 turnaround not driven", {31'd0, ad_oe}, 0);
      end else begin
        chk(!devsel_n && !trdy_n, "R4 trdy held low", {30'd0, devsel_n, trdy_n}, 0);
      end
      if (!irdy_n && !trdy_n) begin
        chk(loc_addr == 4'(off), "R7 offset of finished phase", {28'd0, loc_addr}, off);
        if (wr) begin
          chk(loc_we && !loc_re && loc_wdata == wd, "R5 write data", loc_wdata, wd);
          chk(loc_be == be, "R5 byte enables", {28'd0, loc_be}, {28'd0, be});
          emem[off] = merge(emem[off], wd, be);
        end else begin
          chk(ad_oe && loc_re && ad_out == emem[off], "R6 read data", ad_out, emem[off]);
        end
        off = (off + 1) % NW; done++;
      end else begin
        chk(!loc_we && !loc_re, "R5 no strobe unless both ready",
            {30'd0, loc_we, loc_re}, 0);
      end
      cyc++;
    end
    @(negedge clk);
    frame_n = 1; irdy_n = 1; #1;
    chk(devsel_n && trdy_n && !ad_oe, "R8 release after last phase",
        {29'd0, devsel_n, trdy_n, ad_oe}, 32'h6);
  endtask

  initial begin
    for (int i = 0; i < 300000; i++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NW; i++) begin
      lmem[i] = 32'hA000_0000 + i * 32'h0101_0101;
      emem[i] = 32'hA000_0000 + i * 32'h0101_0101;
    end
    rst_n = 0; frame_n = 1; irdy_n = 1; cbe_n = 4'hF; ad_in = '0;
    repeat (3) @(negedge clk);
    #1 chk(devsel_n && trdy_n && !ad_oe, "R1 reset outputs",
           {29'd0, devsel_n, trdy_n, ad_oe}, 32'h6);
    @(negedge clk); rst_n = 1;
    repeat (2) @(negedge clk);
    #1 chk(devsel_n && trdy_n && !ad_oe, "R1 idle outputs",
           {29'd0, devsel_n, trdy_n, ad_oe}, 32'h6);

    // directed corners
    txn(BASE + 32'h0, 4'b0110, 1, 1);          // R6 single read
    txn(BASE + 32'h4, 4'b0111, 1, 1);          // R5 single write
    txn(BASE + 32'h38, 4'b0111, 4, 1);         // R7 wrap burst write 14,15,0,1
    txn(BASE + 32'h38, 4'b0110, 4, 1);         // R7 wrap burst read back
    txn(32'h5000_0000, 4'b0111, 1, 0);         // R3 address miss
    txn(BASE + 32'h40, 4'b0110, 1, 0);         // R3 just past window
    txn(BASE + 32'h8, 4'b0010, 1, 0);          // R3 unserved command
    txn(BASE + 32'h0, 4'b0110, 16, 1);         // R6 read whole window

    for (int t = 0; t < 40; t++) begin
      txn(BASE + {26'd0, 4'($urandom), 2'b00}, ($urandom % 2) ? 4'b0111 : 4'b0110,
          1 + int'($urandom % 6), 1);
    end
    txn(BASE + 32'h0, 4'b0110, 16, 1);         // final read-back

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule